// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Interface

This block is the bus-facing register file of a colour LCD controller. A host reaches it through a simple single-cycle access port that decodes a 4 KB window. The window holds four display timing words, base addresses for the upper and lower panel frames, and a control word. The control word's enable, power, colour-order, endianness and pixel-depth fields are driven straight out to the pixel pipeline. The block also holds an interrupt mask, raw and masked interrupt status, and a write-one-to-clear register. A read-only identification area sits at the top of the window. A slice of the window is passed through to a separate palette store.

From two of the timing words the block works out the active panel width in pixels and the height in lines. It keeps both values in registers so the fetch and timing logic can use them directly. While the display is both enabled and powered, a frame-rate counter fires once per frame. Each firing sets the next-base and vertical-compare status bits in the same cycle. A registered, level-sensitive interrupt line is high whenever a raised status bit is also unmasked. A build parameter swaps the word slots of the mask and control registers, for both reads and writes, to match either of two software layouts.

Top module: `lcdc_regs`

## Requirements
- R1: In reset and right after it, every stored register reads zero, `bus_rdata` is zero, `irq` and `disp_on` are low, `panel_width` is 16 and `panel_height` is 1.
- R2: An access with `bus_sel` high is taken on one rising edge. A read places its data on `bus_rdata` after that edge, and `bus_rdata` holds until the next read. Word slots 0–3 (timing), 4 (upper base) and 5 (lower base) read back the full 32-bit value last written. Address bits [1:0] are ignored.
- R3: `panel_width` equals (timing word 0 bits [7:2] + 1) × 16 from the edge that writes timing word 0.
- R4: `panel_height` equals timing word 1 bits [9:0] + 1 from the edge that writes timing word 1.
- R5: With `SWAP_MASK_CTRL`=0 the mask is at word slot 6 and control is at slot 7. With 1 the two slots are exchanged for reads and writes. The mask keeps bits [4:0] and control keeps bits [15:0].
- R6: The control fields map as follows: bit 0 is enable, bits [3:1] drive `bpp_code`, bit 8 drives `bgr_order`, bit 9 drives `be_bytes`, bit 10 drives `be_pixels` and bit 11 is power. `disp_on` is high only when bit 0 and bit 11 are both set.
- R7: While `disp_on` is high, raw status bits 2 and 3 are set together once every `TICK_CYCLES` cycles. The first setting comes `TICK_CYCLES` edges after the control write that enabled the display, and every control write restarts the count.
- R8: A control write that leaves `disp_on` low stops the frame count, and raw status then changes only through the clear register.
- R9: Raw status reads at word slot 8 and raw AND mask reads at slot 9. `irq` is high exactly when raw AND mask is nonzero, as of the latest edge.
- R10: A write to word slot 10 clears each raw status bit whose written bit is 1. A frame tick on the same edge wins over the clear.
- R11: Reads of byte offsets 0xFE0–0xFFF return the identification byte (`ID_BYTES` byte ((offset−0xFE0)>>2), least significant byte first), zero-extended. With the default value, the bytes are 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R12: Accesses at byte offsets 0x200–0x3FF pulse `pal_we` or `pal_re` in the access cycle with `pal_idx` = (offset−0x200)>>2. A palette read returns `pal_rdata` on `bus_rdata`.
- R13: Reads of word slots 10, 11, 12 and any unmapped offset return zero. Writes to unmapped offsets change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pal_we | output | 1 | Palette write strobe |
| pal_re | output | 1 | Palette read strobe |
| pal_idx | output | 7 | Palette word index |
| pal_wdata | output | 32 | Palette write data |
| pal_rdata | input | 32 | Palette read data, valid in the access cycle |
| upper_base | output | 32 | Upper panel frame base |
| lower_base | output | 32 | Lower panel frame base |
| panel_width | output | 11 | Active width in pixels |
| panel_height | output | 11 | Active height in lines |
| disp_on | output | 1 | Enable and power both set |
| bpp_code | output | 3 | Pixel depth code |
| bgr_order | output | 1 | Blue/red swap |
| be_bytes | output | 1 | Big-endian byte order |
| be_pixels | output | 1 | Big-endian pixel order in a byte |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that each access lasts exactly one cycle. They also assume that the palette store presents `pal_rdata` in the same cycle as `pal_idx`, and that `bus_wr` is meaningful only when `bus_sel` is high. The bench drives every access as a one-cycle strobe and changes inputs only on the falling edge. Its own palette model answers combinationally from the index. A shortened tick period lets the bench line up a clear write with the exact edge of a frame tick, so that the case where both happen at once is covered.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
  typedef enum logic [3:0] {
    SEL_NONE, SEL_TIM, SEL_UPB, SEL_LPB, SEL_MASK, SEL_CTRL,
    SEL_RAW, SEL_MSKD, SEL_CLR, SEL_PAL, SEL_ID
  } sel_e;

  localparam int SLOT_UPB  = 4;
  localparam int SLOT_LPB  = 5;
  localparam int SLOT_LOW  = 6;
  localparam int SLOT_HIGH = 7;
  localparam int SLOT_RAW  = 8;
  localparam int SLOT_MSKD = 9;
  localparam int SLOT_CLR  = 10;

  localparam int CB_EN     = 0;
  localparam int CB_BPP    = 1;
  localparam int CB_BGR    = 8;
  localparam int CB_BEBYTE = 9;
  localparam int CB_BEPIX  = 10;
  localparam int CB_PWR    = 11;

  localparam int IB_NEXTBASE = 2;
  localparam int IB_VCOMP    = 3;
endpackage

// File: rtl/lcdc_addr_dec.sv
module lcdc_addr_dec
  import lcdc_pkg::*;
#(
  parameter int ADDR_W         = 12,
  parameter int NUM_TIM        = 4,
  parameter int PAL_AW         = 7,
  parameter bit SWAP_MASK_CTRL = 1'b0,
  localparam int TIM_IW        = $clog2(NUM_TIM)
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [TIM_IW-1:0] tim_idx,
  output logic [PAL_AW-1:0] pal_idx,
  output logic [2:0]        id_idx
);
  localparam int IDX_W     = ADDR_W - 2;
  localparam int PAL_LO    = 1 << PAL_AW;
  localparam int PAL_HI    = PAL_LO + (1 << PAL_AW);
  localparam int ID_LO     = (1 << IDX_W) - 8;
  localparam int MASK_SLOT = SWAP_MASK_CTRL ? SLOT_HIGH : SLOT_LOW;
  localparam int CTRL_SLOT = SWAP_MASK_CTRL ? SLOT_LOW : SLOT_HIGH;

  logic [IDX_W-1:0] idx;
  logic [1:0]       unused_byte_lanes;
  logic [31:0]      iv;

  assign idx               = addr[ADDR_W-1:2];
  assign unused_byte_lanes = addr[1:0];
  assign iv                = 32'(idx);
  assign tim_idx           = idx[TIM_IW-1:0];
  assign pal_idx           = idx[PAL_AW-1:0];
  assign id_idx            = idx[2:0];

  always_comb begin
    sel = SEL_NONE;
    if (iv < 32'(NUM_TIM))                               sel = SEL_TIM;
    else if (iv == 32'(SLOT_UPB))                        sel = SEL_UPB;
    else if (iv == 32'(SLOT_LPB))                        sel = SEL_LPB;
    else if (iv == 32'(MASK_SLOT))                       sel = SEL_MASK;
    else if (iv == 32'(CTRL_SLOT))                       sel = SEL_CTRL;
    else if (iv == 32'(SLOT_RAW))                        sel = SEL_RAW;
    else if (iv == 32'(SLOT_MSKD))                       sel = SEL_MSKD;
    else if (iv == 32'(SLOT_CLR))                        sel = SEL_CLR;
    else if (iv >= 32'(PAL_LO) && iv < 32'(PAL_HI))      sel = SEL_PAL;
    else if (iv >= 32'(ID_LO))                           sel = SEL_ID;
  end
endmodule

// File: rtl/lcdc_frame_tick.sv
module lcdc_frame_tick #(
  parameter int TICK_CYCLES = 2083333,
  localparam int CNT_W      = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (restart) cnt <= '0;
    else if (run)     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tick = run && !restart && (cnt == LAST);

  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  assert_restart_zero_R7: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> $stable(cnt));
endmodule

// File: rtl/lcdc_irq_ctrl.sv
module lcdc_irq_ctrl #(
  parameter int IRQ_BITS = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mask_we,
  input  logic [IRQ_BITS-1:0] mask_wdata,
  input  logic                clr_we,
  input  logic [IRQ_BITS-1:0] clr_bits,
  input  logic [IRQ_BITS-1:0] set_bits,
  output logic [IRQ_BITS-1:0] raw,
  output logic [IRQ_BITS-1:0] mask,
  output logic                irq
);
  logic [IRQ_BITS-1:0] raw_n, mask_n;

  always_comb begin
    raw_n  = (clr_we ? (raw & ~clr_bits) : raw) | set_bits;
    mask_n = mask_we ? mask_wdata : mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw  <= '0;
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      raw  <= raw_n;
      mask <= mask_n;
      irq  <= |(raw_n & mask_n);
    end
  end

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (rst)
    irq == |(raw & mask));
  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_we && set_bits == '0) |=> ((raw & $past(clr_bits)) == '0));
  assert_set_R7: assert property (@(posedge clk) disable iff (rst)
    (|set_bits) |=> ((raw & $past(set_bits)) == $past(set_bits)));
endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
  import lcdc_pkg::*;
#(
  parameter int          ADDR_W         = 12,
  parameter int          DATA_W         = 32,
  parameter int          NUM_TIM        = 4,
  parameter int          CTRL_W         = 16,
  parameter int          IRQ_BITS       = 5,
  parameter int          H_FIELD_W      = 6,
  parameter int          V_FIELD_W      = 10,
  parameter int          PAL_AW         = 7,
  parameter int          TICK_CYCLES    = 2083333,
  parameter bit          SWAP_MASK_CTRL = 1'b0,
  parameter logic [63:0] ID_BYTES       = 64'hB105_F00D_0004_1110,
  localparam int         PIX_W          = H_FIELD_W + 5,
  localparam int         LINE_W         = V_FIELD_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pal_we,
  output logic              pal_re,
  output logic [PAL_AW-1:0] pal_idx,
  output logic [DATA_W-1:0] pal_wdata,
  input  logic [DATA_W-1:0] pal_rdata,
  output logic [DATA_W-1:0] upper_base,
  output logic [DATA_W-1:0] lower_base,
  output logic [PIX_W-1:0]  panel_width,
  output logic [LINE_W-1:0] panel_height,
  output logic              disp_on,
  output logic [2:0]        bpp_code,
  output logic              bgr_order,
  output logic              be_bytes,
  output logic              be_pixels,
  output logic              irq
);
  localparam int TIM_IW = $clog2(NUM_TIM);
  localparam logic [IRQ_BITS-1:0] FRAME_BITS =
    IRQ_BITS'((1 << IB_NEXTBASE) | (1 << IB_VCOMP));

  sel_e                sel;
  logic [TIM_IW-1:0]   tim_idx;
  logic [2:0]          id_idx;
  logic                wr_acc, rd_acc;
  logic [NUM_TIM-1:0]  tim_we;
  logic [DATA_W-1:0]   tim_q [NUM_TIM];
  logic [CTRL_W-1:0]   ctrl_q;
  logic                ctrl_we, run, tick;
  logic [IRQ_BITS-1:0] raw, mask;
  logic [DATA_W-1:0]   rd_n;

  lcdc_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_TIM(NUM_TIM), .PAL_AW(PAL_AW),
    .SWAP_MASK_CTRL(SWAP_MASK_CTRL)
  ) u_dec (
    .addr(bus_addr), .sel(sel), .tim_idx(tim_idx),
    .pal_idx(pal_idx), .id_idx(id_idx)
  );

  assign wr_acc = bus_sel && bus_wr;
  assign rd_acc = bus_sel && !bus_wr;

  generate
    for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim_we
      assign tim_we[g] = wr_acc && (sel == SEL_TIM) && (tim_idx == TIM_IW'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_TIM; i++) tim_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_TIM; i++)
        if (tim_we[i]) tim_q[i] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      panel_width  <= PIX_W'(16);
      panel_height <= LINE_W'(1);
    end else begin
      if (tim_we[0])
        panel_width <= (PIX_W'(bus_wdata[H_FIELD_W+1:2]) + PIX_W'(1)) << 4;
      if (tim_we[1])
        panel_height <= LINE_W'(bus_wdata[V_FIELD_W-1:0]) + LINE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_base <= '0;
      lower_base <= '0;
      ctrl_q     <= '0;
    end else if (wr_acc) begin
      if (sel == SEL_UPB)  upper_base <= bus_wdata;
      if (sel == SEL_LPB)  lower_base <= bus_wdata;
      if (sel == SEL_CTRL) ctrl_q     <= bus_wdata[CTRL_W-1:0];
    end
  end

  assign ctrl_we   = wr_acc && (sel == SEL_CTRL);
  assign run       = ctrl_q[CB_EN] && ctrl_q[CB_PWR];
  assign disp_on   = run;
  assign bpp_code  = ctrl_q[CB_BPP+2:CB_BPP];
  assign bgr_order = ctrl_q[CB_BGR];
  assign be_bytes  = ctrl_q[CB_BEBYTE];
  assign be_pixels = ctrl_q[CB_BEPIX];

  lcdc_frame_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst(rst), .restart(ctrl_we), .run(run), .tick(tick)
  );

  lcdc_irq_ctrl #(.IRQ_BITS(IRQ_BITS)) u_irq (
    .clk(clk), .rst(rst),
    .mask_we(wr_acc && (sel == SEL_MASK)),
    .mask_wdata(bus_wdata[IRQ_BITS-1:0]),
    .clr_we(wr_acc && (sel == SEL_CLR)),
    .clr_bits(bus_wdata[IRQ_BITS-1:0]),
    .set_bits(tick ? FRAME_BITS : '0),
    .raw(raw), .mask(mask), .irq(irq)
  );

  assign pal_we    = wr_acc && (sel == SEL_PAL);
  assign pal_re    = rd_acc && (sel == SEL_PAL);
  assign pal_wdata = bus_wdata;

  always_comb begin
    case (sel)
      SEL_TIM:  rd_n = tim_q[tim_idx];
      SEL_UPB:  rd_n = upper_base;
      SEL_LPB:  rd_n = lower_base;
      SEL_MASK: rd_n = DATA_W'(mask);
      SEL_CTRL: rd_n = DATA_W'(ctrl_q);
      SEL_RAW:  rd_n = DATA_W'(raw);
      SEL_MSKD: rd_n = DATA_W'(raw & mask);
      SEL_PAL:  rd_n = pal_rdata;
      SEL_ID:   rd_n = DATA_W'(ID_BYTES[{id_idx, 3'b000} +: 8]);
      default:  rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_n;
  end

  assert_pal_window_R12: assert property (@(posedge clk) disable iff (rst)
    (pal_we || pal_re) |-> (bus_addr >= ADDR_W'(12'h200) && bus_addr < ADDR_W'(12'h400)));
  assert_disp_change_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(disp_on) |-> $past(ctrl_we));
  assert_width_change_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(panel_width) |-> $past(tim_we[0]));
  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_acc |=> $stable(bus_rdata));
endmodule

// File: tb/test_lcdc_regs.sv
module test_lcdc_regs;
  localparam int T = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, pal_wdata, pal_rdata, upper_base, lower_base;
  logic        pal_we, pal_re, disp_on, bgr_order, be_bytes, be_pixels, irq;
  logic [6:0]  pal_idx;
  logic [10:0] panel_width, panel_height;
  logic [2:0]  bpp_code;

  logic [31:0] s_rdata, s_pwdata, s_ub, s_lb;
  logic        s_pwe, s_pre, s_disp, s_bgr, s_beb, s_bep, s_irq;
  logic [6:0]  s_pidx;
  logic [10:0] s_w, s_h;
  logic [2:0]  s_bpp;

  logic [31:0] pal_mem [128];
  int tests = 0, fails = 0;
  bit model_live = 0;

  int unsigned m_tim [4];
  int unsigned m_upb, m_lpb, m_mask, m_ctrl, m_raw, m_cnt, m_rdata;
  byte unsigned id_tab [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  always #4 clk = ~clk;

  assign pal_rdata = pal_mem[pal_idx];
  always @(posedge clk) if (pal_we) pal_mem[pal_idx] <= pal_wdata;

  lcdc_regs #(.TICK_CYCLES(T)) i_lcdc_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pal_we(pal_we), .pal_re(pal_re),
    .pal_idx(pal_idx), .pal_wdata(pal_wdata), .pal_rdata(pal_rdata),
    .upper_base(upper_base), .lower_base(lower_base), .panel_width(panel_width),
    .panel_height(panel_height), .disp_on(disp_on), .bpp_code(bpp_code),
    .bgr_order(bgr_order), .be_bytes(be_bytes), .be_pixels(be_pixels), .irq(irq));

  lcdc_regs #(.TICK_CYCLES(T), .SWAP_MASK_CTRL(1'b1)) i_lcdc_regs_swap (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(s_rdata), .pal_we(s_pwe), .pal_re(s_pre),
    .pal_idx(s_pidx), .pal_wdata(s_pwdata), .pal_rdata(32'h0),
    .upper_base(s_ub), .lower_base(s_lb), .panel_width(s_w),
    .panel_height(s_h), .disp_on(s_disp), .bpp_code(s_bpp),
    .bgr_order(s_bgr), .be_bytes(s_beb), .be_pixels(s_bep), .irq(s_irq));

  task automatic chk(bit ok, string tag, int unsigned act, int unsigned exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int unsigned mread(int unsigned a);
    int unsigned ix = a >> 2;
    if (a >= 'h200 && a < 'h400) return pal_mem[(a - 'h200) >> 2];
    if (a >= 'hFE0) return id_tab[(a - 'hFE0) >> 2];
    case (ix)
      0, 1, 2, 3: return m_tim[ix];
      4: return m_upb;
      5: return m_lpb;
      6: return m_mask;
      7: return m_ctrl;
      8: return m_raw;
      9: return m_raw & m_mask;
      default: return 0;
    endcase
  endfunction

  // behavioural reference, evaluated on the same edge as the design
  always @(posedge clk) begin : model
    int unsigned ix, clr;
    bit run, cwe, tk;
    model_live = 1;
    if (rst) begin
      foreach (m_tim[i]) m_tim[i] = 0;
      m_upb = 0; m_lpb = 0; m_mask = 0; m_ctrl = 0; m_raw = 0; m_cnt = 0; m_rdata = 0;
    end else begin
      ix  = bus_addr >> 2;
      clr = 0;
      run = (m_ctrl & 1) != 0 && (m_ctrl & 'h800) != 0;
      cwe = bus_sel && bus_wr && ix == 7;
      tk  = run && !cwe && m_cnt == T - 1;
      if (cwe) m_cnt = 0;
      else if (run) m_cnt = (m_cnt == T - 1) ? 0 : m_cnt + 1;
      if (bus_sel && !bus_wr) m_rdata = mread(bus_addr);
      if (bus_sel && bus_wr)
        case (ix)
          0, 1, 2, 3: m_tim[ix] = bus_wdata;
          4: m_upb = bus_wdata;
          5: m_lpb = bus_wdata;
          6: m_mask = bus_wdata & 31;
          7: m_ctrl = bus_wdata & 'hFFFF;
          10: clr = bus_wdata & 31;
          default: ;
        endcase
      m_raw = (m_raw & ~clr) | (tk ? 12 : 0);
    end
  end

  always @(negedge clk) if (model_live) begin
    chk(bus_rdata == m_rdata, "R2 rdata vs model", bus_rdata, m_rdata);
    chk(irq == ((m_raw & m_mask) != 0), "R9 irq vs model", irq, (m_raw & m_mask) != 0);
    chk(panel_width == (((m_tim[0] >> 2) & 63) + 1) * 16, "R3 width vs model",
        panel_width, (((m_tim[0] >> 2) & 63) + 1) * 16);
    chk(panel_height == (m_tim[1] & 1023) + 1, "R4 height vs model",
        panel_height, (m_tim[1] & 1023) + 1);
    chk(disp_on == ((m_ctrl & 'h801) == 'h801), "R6 disp_on vs model", disp_on, (m_ctrl & 'h801) == 'h801);
    chk(bpp_code == ((m_ctrl >> 1) & 7), "R6 bpp vs model", bpp_code, (m_ctrl >> 1) & 7);
    chk(upper_base == m_upb && lower_base == m_lpb, "R2 bases vs model", upper_base, m_upb);
  end

  task automatic wr(int unsigned a, int unsigned d);
    bus_sel = 1; bus_wr = 1; bus_addr = 12'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_chk(int unsigned a, int unsigned exp, string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = 12'(a);
    @(negedge clk);
    bus_sel = 0;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    foreach (pal_mem[i]) pal_mem[i] = 0;
    @(negedge clk); idle(3);
    // R1 reset state
    chk(bus_rdata == 0 && irq == 0 && disp_on == 0, "R1 reset outputs", bus_rdata, 0);
    chk(panel_width == 16 && panel_height == 1, "R1 reset geometry", panel_width, 16);
    rst = 0; idle(1);
    rd_chk('h1C, 0, "R1 control zero after reset");

    // R3 / R4 geometry
    wr('h00, 'hFC);  chk(panel_width == 1024, "R3 width max", panel_width, 1024);
    wr('h00, 'h28);  chk(panel_width == 176, "R3 width 176", panel_width, 176);
    wr('h04, 'h3FF); chk(panel_height == 1024, "R4 height max", panel_height, 1024);
    wr('h04, 'hF1DF); chk(panel_height == 480, "R4 height 480", panel_height, 480);

    // R2 plain registers
    wr('h08, 'hDEAD_BEEF); wr('h0C, 'h1234_5678);
    wr('h10, 'h8000_0010); wr('h15, 'h4000_0020);
    rd_chk('h08, 'hDEAD_BEEF, "R2 timing2");
    rd_chk('h0F, 'h1234_5678, "R2 timing3 low bits ignored");
    rd_chk('h10, 'h8000_0010, "R2 upper base");
    rd_chk('h14, 'h4000_0020, "R2 lower base");

    // R5 slot swap
    wr('h18, 'h801);
    chk(disp_on == 0, "R5 slot6 is mask in normal", disp_on, 0);
    chk(s_disp == 1, "R5 slot6 is control in swapped", s_disp, 1);
    rd_chk('h18, 1, "R5 mask keeps 5 bits");
    chk(s_rdata == 'h801, "R5 swapped slot6 readback", s_rdata, 'h801);
    wr('h18, 0);

    // R6 control fields
    wr('h1C, 'h70B);
    chk(bpp_code == 5 && bgr_order && be_bytes && be_pixels, "R6 fields", bpp_code, 5);
    chk(disp_on == 0, "R6 enable without power", disp_on, 0);
    wr('h1C, 'h800);
    chk(disp_on == 0, "R6 power without enable", disp_on, 0);

    // R7 frame tick
    wr('h1C, 'h801);
    chk(disp_on == 1, "R6 enable and power", disp_on, 1);
    idle(T - 4);
    rd_chk('h20, 0, "R7 no tick before period");
    idle(4);
    rd_chk('h20, 'hC, "R7 tick sets bits 2 and 3");
    rd_chk('h24, 0, "R9 masked status with mask clear");

    // R9 irq
    wr('h18, 8); idle(1);
    chk(irq == 1, "R9 irq with unmasked bit", irq, 1);
    rd_chk('h24, 8, "R9 masked status");

    // R8 stop, R10 clear
    wr('h1C, 'h001);
    chk(disp_on == 0, "R8 disabled", disp_on, 0);
    wr('h28, 4);
    rd_chk('h20, 8, "R10 clear bit 2 only");
    chk(irq == 1, "R10 irq still high", irq, 1);
    wr('h28, 8); idle(1);
    chk(irq == 0, "R10 irq low after clear", irq, 0);
    idle(2 * T);
    rd_chk('h20, 0, "R8 no tick while disabled");

    // R10 tick and clear on the same edge
    wr('h1C, 'h801);
    idle(T - 1);
    wr('h28, 'hC);
    rd_chk('h20, 'hC, "R10 tick wins over clear");
    wr('h1C, 'h0);

    // R11 identification
    rd_chk('hFE0, 'h10, "R11 id byte 0");
    rd_chk('hFE8, 'h04, "R11 id byte 2");
    rd_chk('hFFC, 'hB1, "R11 id byte 7");

    // R12 palette
    wr('h204, 'hCAFE_1234);
    chk(pal_mem[1] == 'hCAFE_1234, "R12 palette write index 1", pal_mem[1], 'hCAFE_1234);
    wr('h3FC, 'h55AA);
    chk(pal_mem[127] == 'h55AA, "R12 palette write index 127", pal_mem[127], 'h55AA);
    rd_chk('h204, 'hCAFE_1234, "R12 palette read");

    // R13 unmapped
    wr('h100, 'hFFFF_FFFF);
    rd_chk('h100, 0, "R13 unmapped reads zero");
    rd_chk('h00, 'h28, "R13 timing0 untouched by unmapped write");
    chk(panel_width == 176 && disp_on == 0, "R13 outputs untouched", panel_width, 176);
    rd_chk('h2C, 0, "R13 slot 11 zero");
    rd_chk('h30, 0, "R13 slot 12 zero");
    rd_chk('h28, 0, "R13 clear slot reads zero");
    idle(2);
    finish_run();
  end
endmodule